// File: doc/BRIEF.md
# Byte FIFO with Wide Pseudo-DMA Port

This block is a small byte queue that three agents share: a host register port, a pseudo-DMA port and the bus-side engine. The bus-side engine appears here only as a one-byte push handshake and a one-byte pop handshake. The pseudo-DMA port takes accesses that are one byte or two bytes wide. A two-byte access is taken apart into two byte operations, and the upper byte always goes first. A steering input sends pseudo-DMA writes to a separate command queue instead of the data queue. The command queue is not held in this block: it receives a registered byte count and a data word. An external transfer counter is decremented once for each pseudo-DMA byte that is accepted. The block only reports the decrement amount and never holds the counter.

The occupancy is always visible on a flags output. A data-request line is high while at least two bytes are waiting, so a wide read can always be served. A flush command empties the queue. A pad command tops the queue up with zero bytes until it is full. Pad is used when a command transfer is shorter than a terminal count that fits in the queue. Overflow and underflow are both harmless. A byte pushed into a full queue is dropped and the block pulses an overrun output. A byte popped from an empty queue reads as zero.

Top module: `pdma_byte_fifo`

## Requirements
- R1: The queue holds DEPTH bytes (16 by default). `fifo_flags` reports the number of stored bytes. It is 0 after reset and never exceeds 16.
- R2: A push while the queue is full is dropped. In the next cycle `overrun` is 1, `fifo_flags` stays 16, and the stored bytes are unchanged.
- R3: A pop while the queue is empty returns 0x00 and leaves `fifo_flags` at 0.
- R4: A wide pseudo-DMA write (`pd_wide`=1) stores bits 15:8 first and then bits 7:0. A narrow write stores only bits 7:0.
- R5: A wide pseudo-DMA read puts the first popped byte in bits 15:8 and the second in bits 7:0. A narrow read returns one byte in bits 7:0 with bits 15:8 zero. A missing byte reads as 0x00.
- R6: `tc_dec` is registered and equals the number of pseudo-DMA write bytes accepted in that access. When `tc_zero`=1, no byte is accepted (0). When `tc_one`=1, a wide write accepts only its upper byte (1).
- R7: `drq` is 1 exactly when `fifo_flags` is at least 2. It therefore drops after a pop that leaves fewer than 2 bytes.
- R8: `flush` empties the queue in one cycle and overrides every push, pop and pad.
- R9: With `steer_cmd`=1, pseudo-DMA writes leave the data queue untouched. `cmd_cnt` shows the accepted byte count, and `cmd_data` shows the word with the first byte in bits 15:8 for a wide write, or {0x00, byte} for a narrow one.
- R10: `pad_en` fills every free slot with 0x00, so `fifo_flags` becomes 16. The bytes that were already stored keep their order at the head.
- R11: A one-byte push and a one-byte pop in the same cycle on a queue that is neither empty nor full both complete, and `fifo_flags` is unchanged.
- R12: When several agents request in the same cycle, the pseudo-DMA port wins over the host port, and the host port wins over the bus side. This holds separately for pushes and for pops, and the losing request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the queue |
| pad_en | input | 1 | Fill free slots with zero bytes |
| steer_cmd | input | 1 | Route pseudo-DMA writes to the command queue |
| tc_zero | input | 1 | External transfer counter is zero |
| tc_one | input | 1 | External transfer counter is one |
| hst_wr_en | input | 1 | Host register push |
| hst_wr_data | input | 8 | Host push byte |
| hst_rd_en | input | 1 | Host register pop |
| hst_rd_data | output | 8 | Byte returned by the last host pop |
| sc_push | input | 1 | Bus-side push |
| sc_push_data | input | 8 | Bus-side push byte |
| sc_pop | input | 1 | Bus-side pop |
| sc_pop_data | output | 8 | Byte returned by the last bus-side pop |
| pd_wr_en | input | 1 | Pseudo-DMA write |
| pd_rd_en | input | 1 | Pseudo-DMA read |
| pd_wide | input | 1 | Pseudo-DMA access is two bytes |
| pd_wr_data | input | 16 | Pseudo-DMA write word |
| pd_rd_data | output | 16 | Word returned by the last pseudo-DMA read |
| fifo_flags | output | 5 | Stored byte count |
| drq | output | 1 | Data request, high at two or more bytes |
| overrun | output | 1 | A pushed byte was dropped in the previous cycle |
| tc_dec | output | 2 | Transfer counter decrement for the previous access |
| cmd_cnt | output | 2 | Bytes sent to the command queue |
| cmd_data | output | 16 | Command queue word |

## Verification
The bound checker watches, on every cycle, that the occupancy stays in range and that flush and pad reach their end states. It checks that a push into a full queue raises overrun without moving the count, and that a pop of an empty queue yields zero. It also covers a blocked transfer counter, a falling request line, and a balanced push and pop. Only the bench scenarios can show byte order: the upper-byte-first split of wide accesses, the zero padding behind the kept head bytes, the priority between agents, and the contents of the command-queue word.

// File: rtl/pf_pkg.sv
package pf_pkg;
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_PDMA = 2'd1,
      SRC_HOST = 2'd2,
      SRC_SCSI = 2'd3
   } pop_src_e;
endpackage

// File: rtl/pf_req_decode.sv
module pf_req_decode
   import pf_pkg::*;
(
   input  logic        pd_wr_en,
   input  logic        pd_rd_en,
   input  logic        pd_wide,
   input  logic [15:0] pd_wr_data,
   input  logic        steer_cmd,
   input  logic        tc_zero,
   input  logic        tc_one,
   input  logic        hst_wr_en,
   input  logic [7:0]  hst_wr_data,
   input  logic        hst_rd_en,
   input  logic        sc_push,
   input  logic [7:0]  sc_push_data,
   input  logic        sc_pop,
   output logic [1:0]  push_n,
   output logic [7:0]  push_b0,
   output logic [7:0]  push_b1,
   output logic [1:0]  pop_n,
   output pop_src_e    pop_src,
   output logic [1:0]  pd_n,
   output logic [1:0]  cmd_n,
   output logic [15:0] cmd_word
);
   logic hi_ok, lo_ok;

   // counter gating: each byte needs a nonzero counter at its turn
   assign hi_ok = !tc_zero;
   assign lo_ok = pd_wide && !tc_zero && !tc_one;

   always_comb begin
      pd_n = 2'd0;
      if (pd_wr_en) begin
         pd_n = pd_wide ? (2'(hi_ok) + 2'(lo_ok)) : 2'(hi_ok);
      end
   end

   assign cmd_n    = steer_cmd ? pd_n : 2'd0;
   assign cmd_word = pd_wide ? pd_wr_data : {8'h00, pd_wr_data[7:0]};

   // push arbitration: pseudo-DMA, then host, then bus side
   always_comb begin
      push_n  = 2'd0;
      push_b0 = 8'h00;
      push_b1 = 8'h00;
      if (pd_wr_en && !steer_cmd) begin
         push_n  = pd_n;
         push_b0 = pd_wide ? pd_wr_data[15:8] : pd_wr_data[7:0];
         push_b1 = pd_wr_data[7:0];
      end else if (hst_wr_en) begin
         push_n  = 2'd1;
         push_b0 = hst_wr_data;
      end else if (sc_push) begin
         push_n  = 2'd1;
         push_b0 = sc_push_data;
      end
   end

   // pop arbitration, same order
   always_comb begin
      pop_n   = 2'd0;
      pop_src = SRC_NONE;
      if (pd_rd_en) begin
         pop_n   = pd_wide ? 2'd2 : 2'd1;
         pop_src = SRC_PDMA;
      end else if (hst_rd_en) begin
         pop_n   = 2'd1;
         pop_src = SRC_HOST;
      end else if (sc_pop) begin
         pop_n   = 2'd1;
         pop_src = SRC_SCSI;
      end
   end
endmodule

// File: rtl/pf_store.sv
module pf_store #(
   parameter int DEPTH      = 16,
   parameter int PAD_ENABLE = 1,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          pad,
   input  logic [1:0]    push_n,
   input  logic [7:0]    push_b0,
   input  logic [7:0]    push_b1,
   input  logic [1:0]    pop_n,
   output logic [CW-1:0] count,
   output logic [7:0]    head0,
   output logic [7:0]    head1,
   output logic          pop_taken,
   output logic          overrun
);
   logic [AW-1:0] rd_ptr, wr_ptr;
   logic [CW-1:0] free_w, pop_req, push_req, pop_act, push_act;
   logic          pad_go, move_go;
   logic [7:0]    slot_q [DEPTH];

   generate
      if (PAD_ENABLE != 0) begin : g_pad
         assign pad_go = pad && !flush;
      end else begin : g_nopad
         assign pad_go = 1'b0;
      end
   endgenerate

   assign move_go   = !flush && !pad_go;
   assign pop_taken = move_go;
   assign free_w    = CW'(DEPTH) - count;
   assign pop_req   = CW'(pop_n);
   assign push_req  = CW'(push_n);
   assign pop_act   = (pop_req > count) ? count : pop_req;
   assign push_act  = (push_req > free_w) ? free_w : push_req;

   assign head0 = (count != '0) ? slot_q[rd_ptr] : 8'h00;
   assign head1 = (count > CW'(1)) ? slot_q[rd_ptr + AW'(1)] : 8'h00;

   generate
      for (genvar j = 0; j < DEPTH; j++) begin : g_slot
         logic [AW-1:0] off;
         logic [7:0]    q;
         assign off = AW'(j) - wr_ptr;
         always_ff @(posedge clk) begin
            if (pad_go && (CW'(off) < free_w)) begin
               q <= 8'h00;
            end else if (move_go && off == '0 && push_act != '0) begin
               q <= push_b0;
            end else if (move_go && off == AW'(1) && push_act == CW'(2)) begin
               q <= push_b1;
            end
         end
         assign slot_q[j] = q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr  <= '0;
         wr_ptr  <= '0;
         count   <= '0;
         overrun <= 1'b0;
      end else if (flush) begin
         rd_ptr  <= '0;
         wr_ptr  <= '0;
         count   <= '0;
         overrun <= 1'b0;
      end else if (pad_go) begin
         wr_ptr  <= rd_ptr;
         count   <= CW'(DEPTH);
         overrun <= 1'b0;
      end else begin
         rd_ptr  <= rd_ptr + AW'(pop_act);
         wr_ptr  <= wr_ptr + AW'(push_act);
         count   <= count - pop_act + push_act;
         overrun <= (push_act != push_req);
      end
   end
endmodule

// File: rtl/pdma_byte_fifo.sv
module pdma_byte_fifo
   import pf_pkg::*;
#(
   parameter int DEPTH      = 16,
   parameter int FLAG_W     = 5,
   parameter int DRQ_LEVEL  = 2,
   parameter int PAD_ENABLE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              pad_en,
   input  logic              steer_cmd,
   input  logic              tc_zero,
   input  logic              tc_one,
   input  logic              hst_wr_en,
   input  logic [7:0]        hst_wr_data,
   input  logic              hst_rd_en,
   output logic [7:0]        hst_rd_data,
   input  logic              sc_push,
   input  logic [7:0]        sc_push_data,
   input  logic              sc_pop,
   output logic [7:0]        sc_pop_data,
   input  logic              pd_wr_en,
   input  logic              pd_rd_en,
   input  logic              pd_wide,
   input  logic [15:0]       pd_wr_data,
   output logic [15:0]       pd_rd_data,
   output logic [FLAG_W-1:0] fifo_flags,
   output logic              drq,
   output logic              overrun,
   output logic [1:0]        tc_dec,
   output logic [1:0]        cmd_cnt,
   output logic [15:0]       cmd_data
);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (FLAG_W < CW) begin : g_bad_flags
         $error("FLAG_W too narrow for DEPTH");
      end
      if (DRQ_LEVEL < 1 || DRQ_LEVEL > DEPTH) begin : g_bad_drq
         $error("DRQ_LEVEL out of range");
      end
   endgenerate

   logic [1:0]    push_n, pop_n, pd_n, cmd_n;
   logic [7:0]    push_b0, push_b1, head0, head1;
   logic [15:0]   cmd_word;
   pop_src_e      pop_src;
   logic [CW-1:0] count;
   logic          pop_taken;

   pf_req_decode u_dec (
      .pd_wr_en    (pd_wr_en),
      .pd_rd_en    (pd_rd_en),
      .pd_wide     (pd_wide),
      .pd_wr_data  (pd_wr_data),
      .steer_cmd   (steer_cmd),
      .tc_zero     (tc_zero),
      .tc_one      (tc_one),
      .hst_wr_en   (hst_wr_en),
      .hst_wr_data (hst_wr_data),
      .hst_rd_en   (hst_rd_en),
      .sc_push     (sc_push),
      .sc_push_data(sc_push_data),
      .sc_pop      (sc_pop),
      .push_n      (push_n),
      .push_b0     (push_b0),
      .push_b1     (push_b1),
      .pop_n       (pop_n),
      .pop_src     (pop_src),
      .pd_n        (pd_n),
      .cmd_n       (cmd_n),
      .cmd_word    (cmd_word)
   );

   pf_store #(.DEPTH(DEPTH), .PAD_ENABLE(PAD_ENABLE)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .pad      (pad_en),
      .push_n   (push_n),
      .push_b0  (push_b0),
      .push_b1  (push_b1),
      .pop_n    (pop_n),
      .count    (count),
      .head0    (head0),
      .head1    (head1),
      .pop_taken(pop_taken),
      .overrun  (overrun)
   );

   assign fifo_flags = FLAG_W'(count);
   assign drq        = (count >= CW'(DRQ_LEVEL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hst_rd_data <= 8'h00;
         sc_pop_data <= 8'h00;
         pd_rd_data  <= 16'h0000;
         tc_dec      <= 2'd0;
         cmd_cnt     <= 2'd0;
         cmd_data    <= 16'h0000;
      end else begin
         tc_dec   <= pd_n;
         cmd_cnt  <= cmd_n;
         cmd_data <= cmd_word;
         if (pop_taken) begin
            case (pop_src)
               SRC_PDMA: pd_rd_data  <= pd_wide ? {head0, head1} : {8'h00, head0};
               SRC_HOST: hst_rd_data <= head0;
               SRC_SCSI: sc_pop_data <= head0;
               default:  ;
            endcase
         end
      end
   end
endmodule

// File: rtl/pf_fifo_chk.sv
module pf_fifo_chk #(
   parameter int DEPTH      = 16,
   parameter int FLAG_W     = 5,
   parameter int DRQ_LEVEL  = 2,
   parameter int PAD_ENABLE = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush,
   input logic              pad_en,
   input logic              hst_wr_en,
   input logic              hst_rd_en,
   input logic              sc_push,
   input logic              sc_pop,
   input logic              pd_wr_en,
   input logic              pd_rd_en,
   input logic              tc_zero,
   input logic [FLAG_W-1:0] fifo_flags,
   input logic              drq,
   input logic              overrun,
   input logic [1:0]        tc_dec,
   input logic [7:0]        hst_rd_data
);
   // R1
   flags_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_flags <= FLAG_W'(DEPTH));

   // R2
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_flags == FLAG_W'(DEPTH) && hst_wr_en && !pd_wr_en && !pd_rd_en
       && !hst_rd_en && !sc_pop && !flush && !pad_en)
      |=> (overrun && fifo_flags == FLAG_W'(DEPTH)));

   // R3
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_flags == '0 && hst_rd_en && !pd_rd_en && !pd_wr_en && !hst_wr_en
       && !sc_push && !flush && !pad_en)
      |=> (fifo_flags == '0 && hst_rd_data == 8'h00));

   // R6
   tc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_zero && pd_wr_en) |=> (tc_dec == 2'd0));

   // R7
   drq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drq) |-> (fifo_flags < FLAG_W'(DRQ_LEVEL)));

   // R8
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (fifo_flags == '0 && !drq));

   // R10
   pad_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (PAD_ENABLE != 0 && pad_en && !flush) |=> (fifo_flags == FLAG_W'(DEPTH)));

   // R11
   balanced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_wr_en && sc_pop && !pd_wr_en && !pd_rd_en && !hst_rd_en && !flush
       && !pad_en && fifo_flags != '0 && fifo_flags != FLAG_W'(DEPTH))
      |=> $stable(fifo_flags));
endmodule

bind pdma_byte_fifo pf_fifo_chk #(
   .DEPTH(DEPTH), .FLAG_W(FLAG_W), .DRQ_LEVEL(DRQ_LEVEL), .PAD_ENABLE(PAD_ENABLE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flush      (flush),
   .pad_en     (pad_en),
   .hst_wr_en  (hst_wr_en),
   .hst_rd_en  (hst_rd_en),
   .sc_push    (sc_push),
   .sc_pop     (sc_pop),
   .pd_wr_en   (pd_wr_en),
   .pd_rd_en   (pd_rd_en),
   .tc_zero    (tc_zero),
   .fifo_flags (fifo_flags),
   .drq        (drq),
   .overrun    (overrun),
   .tc_dec     (tc_dec),
   .hst_rd_data(hst_rd_data)
);

// File: tb/test_pdma_byte_fifo.sv
module test_pdma_byte_fifo;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush, pad_en, steer_cmd, tc_zero, tc_one;
   logic        hst_wr_en, hst_rd_en, sc_push, sc_pop, pd_wr_en, pd_rd_en, pd_wide;
   logic [7:0]  hst_wr_data, sc_push_data, hst_rd_data, sc_pop_data;
   logic [15:0] pd_wr_data, pd_rd_data, cmd_data;
   logic [4:0]  fifo_flags;
   logic        drq, overrun;
   logic [1:0]  tc_dec, cmd_cnt;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   pdma_byte_fifo i_pdma_byte_fifo (
      .clk(clk), .rst_n(rst_n), .flush(flush), .pad_en(pad_en),
      .steer_cmd(steer_cmd), .tc_zero(tc_zero), .tc_one(tc_one),
      .hst_wr_en(hst_wr_en), .hst_wr_data(hst_wr_data),
      .hst_rd_en(hst_rd_en), .hst_rd_data(hst_rd_data),
      .sc_push(sc_push), .sc_push_data(sc_push_data),
      .sc_pop(sc_pop), .sc_pop_data(sc_pop_data),
      .pd_wr_en(pd_wr_en), .pd_rd_en(pd_rd_en), .pd_wide(pd_wide),
      .pd_wr_data(pd_wr_data), .pd_rd_data(pd_rd_data),
      .fifo_flags(fifo_flags), .drq(drq), .overrun(overrun),
      .tc_dec(tc_dec), .cmd_cnt(cmd_cnt), .cmd_data(cmd_data)
   );

   // op codes: 0 host push, 1 pd write8, 2 pd write16, 3 pd read8,
   // 4 pd read16, 5 host pop, 6 bus push, 7 bus pop
   // fields: op[40:37] data[36:21] flags[20:16] read value[15:0]
   localparam logic [40:0] VEC [10] = '{
      {4'd0, 16'h0011, 5'd1, 16'h0000},
      {4'd2, 16'hA1B2, 5'd3, 16'h0000},
      {4'd1, 16'h77C3, 5'd4, 16'h0000},
      {4'd6, 16'h0044, 5'd5, 16'h0000},
      {4'd4, 16'h0000, 5'd3, 16'h11A1},
      {4'd5, 16'h0000, 5'd2, 16'h00B2},
      {4'd7, 16'h0000, 5'd1, 16'h00C3},
      {4'd3, 16'h0000, 5'd0, 16'h0044},
      {4'd4, 16'h0000, 5'd0, 16'h0000},
      {4'd5, 16'h0000, 5'd0, 16'h0000}
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle_all();
      flush = 0; pad_en = 0; steer_cmd = 0;
      hst_wr_en = 0; hst_rd_en = 0; sc_push = 0; sc_pop = 0;
      pd_wr_en = 0; pd_rd_en = 0; pd_wide = 0;
      hst_wr_data = 0; sc_push_data = 0; pd_wr_data = 0;
   endtask

   task automatic step();
      @(posedge clk);
      #1;
      idle_all();
   endtask

   task automatic hpush(input logic [7:0] d);
      hst_wr_en = 1; hst_wr_data = d; step();
   endtask

   task automatic hpop();
      hst_rd_en = 1; step();
   endtask

   initial begin
      tc_zero = 0; tc_one = 0;
      idle_all();
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset flags", fifo_flags, 0);
      chk("R7 reset drq", drq, 0);
      chk("R2 reset overrun", overrun, 0);
      chk("R6 reset tc_dec", tc_dec, 0);
      rst_n = 1;
      step();

      // table walk: R4 R5 R3 R1
      for (int i = 0; i < 10; i++) begin
         logic [3:0]  op;
         logic [15:0] d, er;
         logic [4:0]  ef;
         op = VEC[i][40:37]; d = VEC[i][36:21]; ef = VEC[i][20:16]; er = VEC[i][15:0];
         case (op)
            4'd0: begin hst_wr_en = 1; hst_wr_data = d[7:0]; end
            4'd1: begin pd_wr_en = 1; pd_wr_data = d; end
            4'd2: begin pd_wr_en = 1; pd_wide = 1; pd_wr_data = d; end
            4'd3: pd_rd_en = 1;
            4'd4: begin pd_rd_en = 1; pd_wide = 1; end
            4'd5: hst_rd_en = 1;
            4'd6: begin sc_push = 1; sc_push_data = d[7:0]; end
            default: sc_pop = 1;
         endcase
         step();
         chk("R1 R4 table flags", fifo_flags, ef);
         case (op)
            4'd3, 4'd4: chk("R5 R3 table pd read", pd_rd_data, er);
            4'd5: chk("R3 table host read", hst_rd_data, er);
            4'd7: chk("R4 table bus read", sc_pop_data, er);
            default: ;
         endcase
      end

      // R2 fill and overflow
      for (int i = 0; i < 16; i++) hpush(8'h30 + 8'(i));
      chk("R1 full flags", fifo_flags, 16);
      chk("R7 drq full", drq, 1);
      hpush(8'hEE);
      chk("R2 overrun", overrun, 1);
      chk("R2 flags stay full", fifo_flags, 16);
      for (int i = 0; i < 16; i++) begin
         hpop();
         chk("R2 contents kept", hst_rd_data, 8'h30 + 8'(i));
      end
      chk("R2 drained", fifo_flags, 0);

      // R11 balanced push and pop
      hpush(8'h61); hpush(8'h62); hpush(8'h63);
      hst_wr_en = 1; hst_wr_data = 8'h64; sc_pop = 1; step();
      chk("R11 count same", fifo_flags, 3);
      chk("R11 pop data", sc_pop_data, 8'h61);

      // R12 push priority then pop priority
      hst_wr_en = 1; hst_wr_data = 8'h70; sc_push = 1; sc_push_data = 8'h71; step();
      chk("R12 one push", fifo_flags, 4);
      pd_rd_en = 1; pd_wide = 1; hst_rd_en = 1; step();
      chk("R12 pd wins pop", pd_rd_data, 16'h6263);
      chk("R12 two popped", fifo_flags, 2);
      pd_rd_en = 1; step();
      chk("R7 drq drop", drq, 0);
      chk("R12 order", pd_rd_data, 16'h0064);
      hpop();
      chk("R12 host byte kept, bus byte dropped", hst_rd_data, 8'h70);
      chk("R12 empty", fifo_flags, 0);

      // R6 transfer counter gating
      tc_zero = 1; pd_wr_en = 1; pd_wide = 1; pd_wr_data = 16'h1234; step();
      chk("R6 zero counter dec", tc_dec, 0);
      chk("R6 zero counter flags", fifo_flags, 0);
      tc_zero = 0; tc_one = 1; pd_wr_en = 1; pd_wide = 1; pd_wr_data = 16'h5678; step();
      chk("R6 one counter dec", tc_dec, 1);
      chk("R6 one counter flags", fifo_flags, 1);
      tc_one = 0; pd_wr_en = 1; pd_wr_data = 16'hFF9A; step();
      chk("R6 narrow dec", tc_dec, 1);
      pd_wr_en = 1; pd_wide = 1; pd_wr_data = 16'hBCDE; step();
      chk("R6 wide dec", tc_dec, 2);
      chk("R4 flags after writes", fifo_flags, 4);
      pd_rd_en = 1; pd_wide = 1; step();
      chk("R4 R6 high byte kept", pd_rd_data, 16'h569A);
      pd_rd_en = 1; pd_wide = 1; step();
      chk("R4 wide order", pd_rd_data, 16'hBCDE);

      // R9 command steering
      steer_cmd = 1; pd_wr_en = 1; pd_wide = 1; pd_wr_data = 16'h5A6B; step();
      chk("R9 cmd count", cmd_cnt, 2);
      chk("R9 cmd word", cmd_data, 16'h5A6B);
      chk("R9 data queue untouched", fifo_flags, 0);
      steer_cmd = 1; pd_wr_en = 1; pd_wr_data = 16'h99C7; step();
      chk("R9 narrow cmd word", cmd_data, 16'h00C7);
      chk("R9 narrow cmd count", cmd_cnt, 1);

      // R10 padding
      hpush(8'h81);
      chk("R7 one byte no drq", drq, 0);
      hpush(8'h82);
      chk("R7 two bytes drq", drq, 1);
      pad_en = 1; step();
      chk("R10 padded full", fifo_flags, 16);
      hpop(); chk("R10 head kept 1", hst_rd_data, 8'h81);
      hpop(); chk("R10 head kept 2", hst_rd_data, 8'h82);
      hpop(); chk("R10 zero pad byte", hst_rd_data, 8'h00);
      chk("R10 count after pops", fifo_flags, 13);

      // R8 flush overrides a push
      flush = 1; hst_wr_en = 1; hst_wr_data = 8'h55; step();
      chk("R8 flush empties", fifo_flags, 0);
      chk("R8 flush drq", drq, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 10);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule